// File: doc/BRIEF.md
# UART Host Register File

This block is the processor-facing side of a programmable serial port. A host reaches four registers through a 2-bit address with active-high chip select, read and write strobes. At a given address, reading and writing can reach different storage. The block holds the received byte, the byte to send, the line settings (parity, stop bits, data length, automatic flow control), the bit-rate selector and the modem control lines. It also keeps a set of sticky event flags.

The transmitter and receiver cores sit outside and talk to this block through single-cycle strobes. The block issues a one-cycle load pulse with the byte to send. The transmitter pulses a done strobe when that byte has left the line. The receiver pulses a done strobe with the received byte and three error indications, and it pulses a start strobe when it sees a new start bit. The flags clear as side effects of data-register accesses. Each side effect fires once per host strobe, however long the strobe is held. Interrupt lines for transmit, receive and their OR follow the flags.

The modem lines work in one of two modes. In manual mode, the host drives the request and ready outputs directly and reads the two incoming modem inputs. In automatic mode, both outputs are driven low while the receiver can accept a byte. They are driven high when a new frame starts while an unread byte is still held.

Top module: `uart_host_regs`

## Requirements
- R1: During and after synchronous reset, rdata, irq, irq_tx, irq_rx and tx_load are 0, all configuration outputs and baud_sel are 0, and rts_n and dtr_n are 1.
- R2: rdata is registered. It shows the selected register one cycle after a cycle with cs and rd both high, and it is 0 after any cycle where either is low. Address 2 reads as 0.
- R3: A write to address 0 pulses tx_load for exactly one cycle, with tx_data equal to the written byte, even when the write strobe is held for several cycles.
- R4: A write to address 1 sets cfg_hs_en from bit 6, cfg_len from bits 5:4 (00 = five bits up to 11 = eight bits), cfg_stop from bits 3:2 (00 one, 01 one and a half, 10 two, 11 one) and cfg_par from bits 1:0 (00 none, 01 odd, 10 even, 11 none). A write to address 2 sets baud_sel to the written byte.
- R5: A read at address 1 returns status. Bits 7:6 are 0, bit 5 is overrun, bit 4 is framing error, bit 3 is parity error, bit 2 is start-bit error, bit 1 is data received and bit 0 is data transmitted.
- R6: The data-transmitted flag sets on tx_done and clears on a write to address 0. When both happen in the same cycle, the write wins.
- R7: rx_done stores rx_data, sets data-received and ORs the three error inputs into their sticky flags. A read at address 0 returns the stored byte and clears data-received, the three error flags and overrun. When rx_done arrives in the same cycle as that read, the new byte's flags survive and overrun stays clear.
- R8: rx_done while data-received is still set sets overrun and replaces the stored byte.
- R9: irq_tx equals the data-transmitted flag, irq_rx equals the data-received flag, and irq is their OR.
- R10: A read at address 3 returns dsr_n in bit 1 and cts_n in bit 0, with the upper bits 0. With cfg_hs_en low, rts_n follows bit 0 and dtr_n follows bit 1 of the last write to address 3.
- R11: With cfg_hs_en high, rts_n and dtr_n are equal. They are low until rx_start arrives while data-received is set, then high until the next read at address 0.
- R12: A read at address 0 clears the flags only on the first cycle of its strobe. A byte received while the same strobe is still held keeps data-received set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Registered host read data |
| irq | output | 1 | OR of both interrupt lines |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| tx_load | output | 1 | One-cycle load pulse to the transmitter |
| tx_data | output | DATA_W | Byte to send |
| tx_done | input | 1 | Transmitter finished a byte |
| rx_done | input | 1 | Receiver delivered a byte |
| rx_data | input | DATA_W | Received byte, valid with rx_done |
| rx_start_err | input | 1 | Start-bit error, valid with rx_done |
| rx_par_err | input | 1 | Parity error, valid with rx_done |
| rx_frame_err | input | 1 | Stop-bit error, valid with rx_done |
| rx_start | input | 1 | Receiver saw a new start bit |
| cfg_hs_en | output | 1 | Automatic flow control enable |
| cfg_len | output | 2 | Data length code |
| cfg_stop | output | 2 | Stop bit code |
| cfg_par | output | 2 | Parity code |
| baud_sel | output | DATA_W | Bit-rate selector |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| cts_n | input | 1 | Clear-to-send input |
| dsr_n | input | 1 | Set-ready input |

## Verification
The flags are visible only through the status read and the two interrupt lines. A flag stuck set, or cleared on the wrong edge, shows on irq_tx or irq_rx in the cycle after the strobe that should have changed it. The status byte read one cycle later shows the same fault. A strobe detector that fires on every held cycle shows up in two ways: tx_load pulses more than once, and a byte received during a held data read comes back with data-received already cleared. The sweeps run through every configuration byte, every bit-rate byte and every error combination, so a swapped or shifted field appears at the first value that exercises it.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int ADDR_W   = 2;
  localparam int NUM_REGS = 1 << ADDR_W;

  // register addresses
  localparam int A_DATA  = 0;
  localparam int A_STAT  = 1;
  localparam int A_BAUD  = 2;
  localparam int A_MODEM = 3;

  // status bit positions (host software decodes these)
  localparam int ST_DT    = 0;
  localparam int ST_DR    = 1;
  localparam int ST_SE    = 2;
  localparam int ST_PE    = 3;
  localparam int ST_FE    = 4;
  localparam int ST_OV    = 5;
  localparam int ST_FLAGS = 6;

  // line settings, packed in host bit order 6..0
  typedef struct packed {
    logic       hs_en;
    logic [1:0] len;
    logic [1:0] stop;
    logic [1:0] par;
  } line_cfg_t;

  localparam int CFG_W = $bits(line_cfg_t);
endpackage

// File: rtl/uart_strobe_edge.sv
module uart_strobe_edge #(
  parameter int AW  = 2,
  parameter int NUM = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs,
  input  logic           rd,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  output logic [NUM-1:0] rd_hit,
  output logic [NUM-1:0] wr_hit
);
  logic rd_act, wr_act, rd_act_q, wr_act_q, rd_new, wr_new;

  assign rd_act = cs & rd;
  assign wr_act = cs & wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
    end
  end

  assign rd_new = rd_act & ~rd_act_q;
  assign wr_new = wr_act & ~wr_act_q;

  for (genvar g = 0; g < NUM; g++) begin : g_dec
    assign rd_hit[g] = rd_new && (addr == AW'(g));
    assign wr_hit[g] = wr_new && (addr == AW'(g));
  end
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_regs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_done,
  input  logic                tx_clr,
  input  logic                rx_done,
  input  logic [DW-1:0]       rx_byte,
  input  logic                rx_start_err,
  input  logic                rx_par_err,
  input  logic                rx_frame_err,
  input  logic                rx_clr,
  output logic [DW-1:0]       rx_hold,
  output logic [ST_FLAGS-1:0] flags
);
  logic dt_q, dr_q, se_q, pe_q, fe_q, ov_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dt_q    <= 1'b0;
      dr_q    <= 1'b0;
      se_q    <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      ov_q    <= 1'b0;
      rx_hold <= '0;
    end else begin
      if (tx_clr)       dt_q <= 1'b0;
      else if (tx_done) dt_q <= 1'b1;

      if (rx_done) begin
        rx_hold <= rx_byte;
        dr_q    <= 1'b1;
        se_q    <= (se_q & ~rx_clr) | rx_start_err;
        pe_q    <= (pe_q & ~rx_clr) | rx_par_err;
        fe_q    <= (fe_q & ~rx_clr) | rx_frame_err;
        ov_q    <= ~rx_clr & (ov_q | dr_q);
      end else if (rx_clr) begin
        dr_q <= 1'b0;
        se_q <= 1'b0;
        pe_q <= 1'b0;
        fe_q <= 1'b0;
        ov_q <= 1'b0;
      end
    end
  end

  always_comb begin
    flags        = '0;
    flags[ST_DT] = dt_q;
    flags[ST_DR] = dr_q;
    flags[ST_SE] = se_q;
    flags[ST_PE] = pe_q;
    flags[ST_FE] = fe_q;
    flags[ST_OV] = ov_q;
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       hs_en,
  input  logic       wr_hit,
  input  logic [1:0] wbits,
  input  logic       rx_start,
  input  logic       rx_pending,
  input  logic       rx_clr,
  input  logic       cts_n,
  input  logic       dsr_n,
  output logic       rts_n,
  output logic       dtr_n,
  output logic [1:0] line_in
);
  logic [1:0] man_q;
  logic       hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      man_q  <= 2'b11;
      hold_q <= 1'b0;
    end else begin
      if (wr_hit) man_q <= wbits;
      if (!hs_en || rx_clr)            hold_q <= 1'b0;
      else if (rx_start && rx_pending) hold_q <= 1'b1;
    end
  end

  assign rts_n   = hs_en ? hold_q : man_q[0];
  assign dtr_n   = hs_en ? hold_q : man_q[1];
  assign line_in = {dsr_n, cts_n};
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_start_err,
  input  logic              rx_par_err,
  input  logic              rx_frame_err,
  input  logic              rx_start,
  output logic              cfg_hs_en,
  output logic [1:0]        cfg_len,
  output logic [1:0]        cfg_stop,
  output logic [1:0]        cfg_par,
  output logic [DATA_W-1:0] baud_sel,
  output logic              rts_n,
  output logic              dtr_n,
  input  logic              cts_n,
  input  logic              dsr_n
);
  logic [NUM_REGS-1:0] rd_hit, wr_hit;
  logic [DATA_W-1:0]   rx_hold, rd_sel;
  logic [ST_FLAGS-1:0] flags;
  logic [1:0]          line_in;
  line_cfg_t           cfg_q;

  uart_strobe_edge #(.AW(ADDR_W), .NUM(NUM_REGS)) u_edge (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  uart_status_flags #(.DW(DATA_W)) u_flags (
    .clk(clk), .rst(rst),
    .tx_done(tx_done), .tx_clr(wr_hit[A_DATA]),
    .rx_done(rx_done), .rx_byte(rx_data),
    .rx_start_err(rx_start_err), .rx_par_err(rx_par_err),
    .rx_frame_err(rx_frame_err), .rx_clr(rd_hit[A_DATA]),
    .rx_hold(rx_hold), .flags(flags)
  );

  uart_modem_ctl u_modem (
    .clk(clk), .rst(rst), .hs_en(cfg_q.hs_en),
    .wr_hit(wr_hit[A_MODEM]), .wbits(wdata[1:0]),
    .rx_start(rx_start), .rx_pending(flags[ST_DR]),
    .rx_clr(rd_hit[A_DATA]), .cts_n(cts_n), .dsr_n(dsr_n),
    .rts_n(rts_n), .dtr_n(dtr_n), .line_in(line_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      baud_sel <= '0;
      tx_data  <= '0;
      tx_load  <= 1'b0;
    end else begin
      tx_load <= wr_hit[A_DATA];
      if (wr_hit[A_DATA]) tx_data  <= wdata;
      if (wr_hit[A_STAT]) cfg_q    <= line_cfg_t'(wdata[CFG_W-1:0]);
      if (wr_hit[A_BAUD]) baud_sel <= wdata;
    end
  end

  always_comb begin
    case (addr)
      2'(A_DATA):  rd_sel = rx_hold;
      2'(A_STAT):  rd_sel = DATA_W'(flags);
      2'(A_MODEM): rd_sel = DATA_W'(line_in);
      default:     rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata <= '0;
    else if (cs && rd) rdata <= rd_sel;
    else               rdata <= '0;
  end

  assign cfg_hs_en = cfg_q.hs_en;
  assign cfg_len   = cfg_q.len;
  assign cfg_stop  = cfg_q.stop;
  assign cfg_par   = cfg_q.par;
  assign irq_tx    = flags[ST_DT];
  assign irq_rx    = flags[ST_DR];
  assign irq       = irq_tx | irq_rx;
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              rd,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              tx_load,
  input logic              rx_done,
  input logic              cfg_hs_en,
  input logic              rts_n,
  input logic              dtr_n,
  input logic              cts_n,
  input logic              dsr_n
);
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> rdata == '0); // R2

  AST_TX_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load); // R3

  AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == 2'(A_STAT)) |=> rdata[DATA_W-1:ST_FLAGS] == '0); // R5

  AST_LOAD_CLEARS_DT: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> !irq_tx); // R6

  AST_RX_SETS_DR: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> irq_rx); // R7

  AST_MODEM_READ: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == 2'(A_MODEM)) |=> rdata == DATA_W'({$past(dsr_n), $past(cts_n)})); // R10

  AST_LOCAL_LINES_PAIRED: assert property (@(posedge clk) disable iff (rst)
    cfg_hs_en |-> rts_n == dtr_n); // R11
endmodule

bind uart_host_regs uart_host_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .addr(addr), .rdata(rdata),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .tx_load(tx_load), .rx_done(rx_done),
  .cfg_hs_en(cfg_hs_en), .rts_n(rts_n), .dtr_n(dtr_n),
  .cts_n(cts_n), .dsr_n(dsr_n)
);

// File: tb/uart_host_regs_test.sv
`timescale 1ns/1ps
module uart_host_regs_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, tx_data, baud_sel, rx_data = 0;
  logic       irq, irq_tx, irq_rx, tx_load;
  logic       tx_done = 0, rx_done = 0, rx_start = 0;
  logic       rx_start_err = 0, rx_par_err = 0, rx_frame_err = 0;
  logic       cfg_hs_en, rts_n, dtr_n, cts_n = 0, dsr_n = 0;
  logic [1:0] cfg_len, cfg_stop, cfg_par;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  uart_host_regs #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .tx_load(tx_load), .tx_data(tx_data), .tx_done(tx_done),
    .rx_done(rx_done), .rx_data(rx_data), .rx_start_err(rx_start_err),
    .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err), .rx_start(rx_start),
    .cfg_hs_en(cfg_hs_en), .cfg_len(cfg_len), .cfg_stop(cfg_stop),
    .cfg_par(cfg_par), .baud_sel(baud_sel), .rts_n(rts_n), .dtr_n(dtr_n),
    .cts_n(cts_n), .dsr_n(dsr_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write, holding the strobe for hold cycles; returns tx_load pulse count
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d,
                        input int hold, output int pulses);
    pulses = 0;
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); pulses += int'(tx_load);
    end
    cs = 0; wr = 0;
    @(negedge clk); pulses += int'(tx_load);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); d = rdata;
    cs = 0; rd = 0;
  endtask

  task automatic rx_pulse(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk);
    rx_done = 1; rx_data = d;
    rx_start_err = e[0]; rx_par_err = e[1]; rx_frame_err = e[2];
    @(negedge clk);
    rx_done = 0; rx_start_err = 0; rx_par_err = 0; rx_frame_err = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int p;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", {irq, irq_tx, irq_rx, tx_load}, 0);
    chk("R1 cfg", {cfg_hs_en, cfg_len, cfg_stop, cfg_par}, 0);
    chk("R1 baud", baud_sel, 0);
    chk("R1 lines", {dtr_n, rts_n}, 3);

    // R2 idle read data is zero
    cts_n = 1; dsr_n = 1;
    @(negedge clk); cs = 1; rd = 0; addr = 3;
    @(negedge clk); chk("R2 cs only", rdata, 0);
    cs = 0; rd = 1;
    @(negedge clk); chk("R2 rd only", rdata, 0);
    rd = 0;
    bus_rd(2, v); chk("R2 addr2 reads zero", v, 0);

    // R10 modem inputs and manual outputs
    for (int k = 0; k < 4; k++) begin
      cts_n = k[0]; dsr_n = k[1];
      bus_rd(3, v); chk("R10 modem read", v, k);
      bus_wr(3, 8'(k), 1, p); chk("R10 manual lines", {dtr_n, rts_n}, k);
    end

    // R4 configuration and bit-rate sweeps
    for (int k = 0; k < 128; k++) begin
      bus_wr(1, 8'(k), 1, p);
      chk("R4 cfg fields", {cfg_hs_en, cfg_len, cfg_stop, cfg_par}, k);
    end
    bus_wr(1, 8'h00, 1, p);
    for (int k = 0; k < 256; k++) begin
      bus_wr(2, 8'(k), 1, p); chk("R4 baud", baud_sel, k);
    end

    // R3 single load pulse
    for (int h = 1; h <= 4; h++) begin
      bus_wr(0, 8'(8'h5A + h * 37), h, p);
      chk("R3 one pulse", p, 1);
      chk("R3 tx data", tx_data, 8'(8'h5A + h * 37));
    end

    // R6 transmitted flag
    pulse(tx_done);
    chk("R6 set", irq_tx, 1);
    bus_rd(1, v); chk("R5 status DT bit0", v, 8'h01);
    bus_wr(0, 8'h11, 1, p); chk("R6 cleared by write", irq_tx, 0);
    pulse(tx_done);
    @(negedge clk); cs = 1; wr = 1; addr = 0; wdata = 8'h22; tx_done = 1;
    @(negedge clk); cs = 0; wr = 0; tx_done = 0;
    chk("R6 write wins", irq_tx, 0);

    // R7 and R5 received byte with every error combination
    for (int e = 0; e < 8; e++) begin
      rx_pulse(8'(8'h30 + e * 17), 3'(e));
      chk("R9 irq_rx", {irq, irq_rx}, 3);
      bus_rd(1, v); chk("R5 status layout", v, (e << 2) | 2);
      bus_rd(0, v); chk("R7 rx byte", v, 8'(8'h30 + e * 17));
      bus_rd(1, v); chk("R7 cleared", v, 0);
    end

    // R8 overrun, sticky errors carried
    rx_pulse(8'hA1, 3'b010);
    rx_pulse(8'hB2, 3'b000);
    bus_rd(1, v); chk("R8 overrun status", v, 8'h2A);
    bus_rd(0, v); chk("R8 newest byte", v, 8'hB2);
    bus_rd(1, v); chk("R8 cleared", v, 0);

    // R7 receive in the same cycle as the clearing read
    rx_pulse(8'hC3, 3'b000);
    @(negedge clk); cs = 1; rd = 1; addr = 0; rx_done = 1; rx_data = 8'hD4;
    @(negedge clk); v = rdata; cs = 0; rd = 0; rx_done = 0;
    chk("R7 old byte read", v, 8'hC3);
    bus_rd(1, v); chk("R7 same-cycle rx survives", v, 8'h02);
    bus_rd(0, v); chk("R7 new byte", v, 8'hD4);

    // R12 held read clears only once
    rx_pulse(8'hE5, 3'b000);
    @(negedge clk); cs = 1; rd = 1; addr = 0;
    @(negedge clk); rx_done = 1; rx_data = 8'hF6;
    @(negedge clk); rx_done = 0;
    @(negedge clk); @(negedge clk); cs = 0; rd = 0;
    chk("R12 irq_rx kept", irq_rx, 1);
    bus_rd(1, v); chk("R12 status", v, 8'h02);
    bus_rd(0, v); chk("R12 byte", v, 8'hF6);

    // R9 interrupt combinations
    chk("R9 none", {irq, irq_tx, irq_rx}, 0);
    pulse(tx_done); chk("R9 tx only", {irq, irq_tx, irq_rx}, 6);
    rx_pulse(8'h01, 0); chk("R9 both", {irq, irq_tx, irq_rx}, 7);
    bus_wr(0, 8'h00, 1, p); chk("R9 rx only", {irq, irq_tx, irq_rx}, 5);
    bus_rd(0, v);

    // R11 automatic flow control
    bus_wr(3, 8'h02, 1, p);
    bus_wr(1, 8'h40, 1, p);
    chk("R11 ready low", {dtr_n, rts_n}, 0);
    pulse(rx_start); chk("R11 start without byte", {dtr_n, rts_n}, 0);
    rx_pulse(8'h77, 0);
    pulse(rx_start); chk("R11 held high", {dtr_n, rts_n}, 3);
    bus_rd(0, v); chk("R11 released by read", {dtr_n, rts_n}, 0);
    bus_wr(1, 8'h00, 1, p); chk("R10 manual restored", {dtr_n, rts_n}, 2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule